// File: doc/BRIEF.md
# Multi-Output Level Interrupt Aggregator

This block gathers many level-sensitive interrupt sources, grouped into 32-bit words, and reduces them to a small set of upstream interrupt lines. Software reaches each word through a pair of registers on a simple memory-mapped bus: a read/write enable register that masks or unmasks individual sources, and a read-only status register that shows the live source levels. Every upstream output has its own fixed routing mask for each word. An output asserts when any source is high, enabled and routed to it. There is no acknowledge and no write-to-clear: an output stays high for as long as a qualifying source is held high.

The enable registers leave reset holding a build-time forward mask, so some sources reach their outputs before software writes anything. A suspend input widens the effective enable of each word by a fixed wake mask. While suspend is high, the block also raises a wake request whenever a wake-capable source is active. When suspend is dropped, only the programmed enables apply again. Bits that no output's routing mask covers are treated as absent: they read as zero and cannot be enabled.

Top module: `lvl_irq_fanin`

## Requirements
- R1: After reset, each word's enable register reads back its forward-mask value ANDed with that word's coverage, where coverage is the OR of every output's routing mask for the word. `irq_out` and `wake_req` are low.
- R2: Word w occupies byte addresses 8*w to 8*w+7. Its enable register is at offset 0 and its status register at offset 4. A read at any other offset returns zero, and `bus_rdata` is zero whenever no read is selected.
- R3: A write to an enable register stores the written data ANDed with the word's coverage, and the value is visible on the next read. A 1 bit unmasks a source and a 0 bit masks it. Enable registers change only when they are written.
- R4: A status read returns the live `src_in` level of the word ANDed with its coverage. A write to a status address changes no register.
- R5: `irq_out[o]` is the OR, over all words, of source AND effective enable AND output o's routing mask for the word. It is registered, so it changes on the first rising edge after its inputs change.
- R6: A source reaches only the outputs whose routing mask contains its bit. Routing masks are packed output-major: the slice for output o, word w starts at bit (o*NUM_WORDS+w)*32.
- R7: Outputs are pure level. An output stays high while its source is held and falls one edge after the source drops, with no acknowledge.
- R8: While `suspend` is high, each word's effective enable is its enable register OR its wake mask. When `suspend` is low, the enable register alone applies.
- R9: `wake_req` is registered. It is high when, on the previous edge, `suspend` was high and some source was high in the wake mask and in the coverage.
- R10: A source bit outside every routing mask reads as zero in status, stays zero in the enable register whatever is written, and drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_in | input | NUM_WORDS*32 | Level sources, word w at bits [32w+31:32w] |
| suspend | input | 1 | Suspend state, enables the wake path |
| irq_out | output | NUM_OUTS | Upstream interrupt lines |
| wake_req | output | 1 | Wake request |

## Verification
On every cycle, the assertions check that an enable register changes only on its own write decode and then holds the masked write data. They also check that uncovered status bits and off-grid reads return zero, that no output rises without a source having been high the cycle before, and that a wake request never appears without a prior suspend. The bench's scenarios are needed for the rest: the reset forward-mask values, the per-output routing separation, the one-edge latency, the level hold and release, the fact that a status write has no effect, and the way suspend widens the enables and then restores them. A reference model of the enable registers drives its queue of expected values.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int WORD_BITS = 32;
  localparam logic [2:0] OFF_ENABLE = 3'd0;
  localparam logic [2:0] OFF_STATUS = 3'd4;

  typedef logic [WORD_BITS-1:0] word_t;

  // pending bits of one word as seen by one output
  function automatic word_t pend_word(word_t lvl, word_t en, word_t route);
    return lvl & en & route;
  endfunction

  // enable in force, widened by the wake mask during suspend
  function automatic word_t eff_enable(word_t en, word_t wake, logic susp);
    return susp ? (en | wake) : en;
  endfunction

  function automatic logic word_any(word_t v);
    return |v;
  endfunction
endpackage

// File: rtl/lvl_irq_cover.sv
module lvl_irq_cover #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_OUTS = 2,
  parameter bit ROUTE_USED = 1'b1,
  parameter logic [NUM_OUTS*NUM_WORDS*32-1:0] ROUTE_MASK = '1
) (
  output logic [NUM_OUTS*NUM_WORDS*32-1:0] route_flat,
  output logic [NUM_WORDS*32-1:0] cover_flat
);
  localparam int SLICE = 32;

  generate
    if (ROUTE_USED) begin : g_routed
      assign route_flat = ROUTE_MASK;
    end else begin : g_open
      assign route_flat = '1;
    end
  endgenerate

  always_comb begin
    cover_flat = '0;
    for (int o = 0; o < NUM_OUTS; o++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        cover_flat[w*SLICE +: SLICE] = cover_flat[w*SLICE +: SLICE]
                                       | route_flat[(o*NUM_WORDS+w)*SLICE +: SLICE];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs import lvl_irq_pkg::*; #(
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W = 5,
  parameter logic [NUM_WORDS*32-1:0] FWD_MASK = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [NUM_WORDS*32-1:0] src_in,
  input  logic [NUM_WORDS*32-1:0] cover_flat,
  output logic [NUM_WORDS*32-1:0] en_flat,
  output logic [NUM_WORDS-1:0] en_wr_vec,
  output logic [31:0] rdata
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] word_idx;
  logic [2:0] byte_off;
  logic idx_ok;
  logic rd_act;
  word_t en_arr [NUM_WORDS];
  word_t stat_arr [NUM_WORDS];

  assign word_idx = bus_addr[ADDR_W-1:3];
  assign byte_off = bus_addr[2:0];
  assign idx_ok = (32'(word_idx) < NUM_WORDS);
  assign rd_act = bus_sel & ~bus_wr & idx_ok;

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      word_t cov_w;
      word_t en_q;
      assign cov_w = cover_flat[w*32 +: 32];
      assign en_wr_vec[w] = bus_sel & bus_wr & idx_ok
                            & (byte_off == OFF_ENABLE) & (32'(word_idx) == w);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= FWD_MASK[w*32 +: 32] & cov_w;
        end else if (en_wr_vec[w]) begin
          en_q <= bus_wdata & cov_w;
        end
      end

      assign en_flat[w*32 +: 32] = en_q;
      assign en_arr[w] = en_q;
      assign stat_arr[w] = src_in[w*32 +: 32] & cov_w;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_act) begin
      case (byte_off)
        OFF_ENABLE: rdata = en_arr[word_idx];
        OFF_STATUS: rdata = stat_arr[word_idx];
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lvl_irq_wake.sv
module lvl_irq_wake import lvl_irq_pkg::*; #(
  parameter int NUM_WORDS = 4,
  parameter bit WAKE_EN = 1'b1,
  parameter logic [NUM_WORDS*32-1:0] WAKE_MASK = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend,
  input  logic [NUM_WORDS*32-1:0] src_in,
  input  logic [NUM_WORDS*32-1:0] cover_flat,
  input  logic [NUM_WORDS*32-1:0] en_flat,
  output logic [NUM_WORDS*32-1:0] en_eff,
  output logic wake_hit,
  output logic wake_q
);
  generate
    if (WAKE_EN) begin : g_wake
      always_comb begin
        wake_hit = 1'b0;
        for (int w = 0; w < NUM_WORDS; w++) begin
          en_eff[w*32 +: 32] = eff_enable(en_flat[w*32 +: 32],
                                          WAKE_MASK[w*32 +: 32], suspend);
          wake_hit = wake_hit | word_any(pend_word(src_in[w*32 +: 32],
                                                   WAKE_MASK[w*32 +: 32],
                                                   cover_flat[w*32 +: 32]));
        end
        wake_hit = wake_hit & suspend;
      end
    end else begin : g_nowake
      assign en_eff = en_flat;
      assign wake_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_hit;
  end
endmodule

// File: rtl/lvl_irq_outlane.sv
module lvl_irq_outlane import lvl_irq_pkg::*; #(
  parameter int NUM_WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_WORDS*32-1:0] src_in,
  input  logic [NUM_WORDS*32-1:0] en_eff,
  input  logic [NUM_WORDS*32-1:0] route_lane,
  output logic pend_any,
  output logic irq_q
);
  always_comb begin
    pend_any = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      pend_any = pend_any | word_any(pend_word(src_in[w*32 +: 32],
                                               en_eff[w*32 +: 32],
                                               route_lane[w*32 +: 32]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end
endmodule

// File: rtl/lvl_irq_fanin.sv
module lvl_irq_fanin #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_OUTS = 2,
  parameter int ADDR_W = 5,
  parameter bit ROUTE_USED = 1'b1,
  parameter logic [NUM_OUTS*NUM_WORDS*32-1:0] ROUTE_MASK = {
    32'h0000_0000, 32'h0000_0F00, 32'h0000_FFFF, 32'hFFFF_0000,
    32'h0000_0000, 32'h0000_00FF, 32'hFFFF_0000, 32'h0000_FFFF},
  parameter logic [NUM_WORDS*32-1:0] FWD_MASK = {
    32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_0000, 32'h0000_0011},
  parameter bit WAKE_EN = 1'b1,
  parameter logic [NUM_WORDS*32-1:0] WAKE_MASK = {
    32'h0000_0000, 32'h0000_0800, 32'h0000_0000, 32'h0000_0100}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel,
  input  logic bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [NUM_WORDS*32-1:0] src_in,
  input  logic suspend,
  output logic [NUM_OUTS-1:0] irq_out,
  output logic wake_req
);
  localparam int LANE_W = NUM_WORDS * 32;

  logic [NUM_OUTS*LANE_W-1:0] route_flat;
  logic [LANE_W-1:0] cover_flat;
  logic [LANE_W-1:0] en_flat;
  logic [LANE_W-1:0] en_eff;
  logic [NUM_WORDS-1:0] en_wr_vec;
  logic [NUM_OUTS-1:0] lane_pend;
  logic wake_hit;

  lvl_irq_cover #(
    .NUM_WORDS(NUM_WORDS), .NUM_OUTS(NUM_OUTS),
    .ROUTE_USED(ROUTE_USED), .ROUTE_MASK(ROUTE_MASK)
  ) u_cover (
    .route_flat(route_flat),
    .cover_flat(cover_flat)
  );

  lvl_irq_regs #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .FWD_MASK(FWD_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .src_in(src_in), .cover_flat(cover_flat),
    .en_flat(en_flat), .en_wr_vec(en_wr_vec), .rdata(bus_rdata)
  );

  lvl_irq_wake #(
    .NUM_WORDS(NUM_WORDS), .WAKE_EN(WAKE_EN), .WAKE_MASK(WAKE_MASK)
  ) u_wake (
    .clk(clk), .rst_n(rst_n), .suspend(suspend),
    .src_in(src_in), .cover_flat(cover_flat), .en_flat(en_flat),
    .en_eff(en_eff), .wake_hit(wake_hit), .wake_q(wake_req)
  );

  generate
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_lane
      lvl_irq_outlane #(.NUM_WORDS(NUM_WORDS)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .src_in(src_in), .en_eff(en_eff),
        .route_lane(route_flat[o*LANE_W +: LANE_W]),
        .pend_any(lane_pend[o]),
        .irq_q(irq_out[o])
      );
    end
  endgenerate
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
  parameter int NUM_WORDS = 4,
  parameter int NUM_OUTS = 2,
  parameter int ADDR_W = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bus_sel,
  input logic bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [NUM_WORDS*32-1:0] src_in,
  input logic suspend,
  input logic [NUM_OUTS-1:0] irq_out,
  input logic wake_req,
  input logic [NUM_WORDS*32-1:0] en_flat,
  input logic [NUM_WORDS-1:0] en_wr_vec,
  input logic [NUM_WORDS*32-1:0] cover_flat
);
  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
      assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_wr_vec[w]))
          |-> (en_flat[w*32 +: 32] == ($past(bus_wdata) & cover_flat[w*32 +: 32])));

      assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_wr_vec[w])) |-> $stable(en_flat[w*32 +: 32]));

      assert_status_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[2:0] == 3'd4 && int'(bus_addr[ADDR_W-1:3]) == w)
          |-> ((bus_rdata & ~cover_flat[w*32 +: 32]) == 32'd0));
    end
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_o
      assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_out[o]) |-> $past(|src_in));
    end
  endgenerate

  assert_offgrid_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'd0) |-> (bus_rdata == 32'd0));

  assert_wake_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wake_req) |-> $past(suspend));
endmodule

bind lvl_irq_fanin lvl_irq_chk #(
  .NUM_WORDS(NUM_WORDS), .NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .src_in(src_in), .suspend(suspend), .irq_out(irq_out), .wake_req(wake_req),
  .en_flat(en_flat), .en_wr_vec(en_wr_vec), .cover_flat(cover_flat)
);

// File: tb/lvl_irq_fanin_bench.sv
module lvl_irq_fanin_bench;
  localparam int NW = 4;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NW*32-1:0] src_b = '0;
  logic suspend = 1'b0;
  logic [NO-1:0] irq_out;
  logic wake_req;

  always #4 clk = ~clk;

  lvl_irq_fanin u_lvl_irq_fanin (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_b), .suspend(suspend), .irq_out(irq_out), .wake_req(wake_req)
  );

  // independent restatement of the build constants
  logic [31:0] route_m [NO][NW] = '{
    '{32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_00FF, 32'h0},
    '{32'hFFFF_0000, 32'h0000_FFFF, 32'h0000_0F00, 32'h0}};
  logic [31:0] fwd_m  [NW] = '{32'h11, 32'h0001_0000, 32'h0, 32'hFFFF_FFFF};
  logic [31:0] wake_m [NW] = '{32'h100, 32'h0, 32'h800, 32'h0};
  logic [31:0] en_m   [NW];

  function automatic logic [31:0] cov(int w);
    return route_m[0][w] | route_m[1][w];
  endfunction

  function automatic logic exp_irq(int o);
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) begin
      logic [31:0] e = suspend ? (en_m[w] | wake_m[w]) : en_m[w];
      r = r | (|(src_b[w*32 +: 32] & e & route_m[o][w]));
    end
    return r;
  endfunction

  function automatic logic exp_wake();
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) r = r | (|(src_b[w*32 +: 32] & wake_m[w] & cov(w)));
    return r & suspend;
  endfunction

  // scoreboard
  typedef struct { string tag; int kind; logic [31:0] exp; } item_t;
  item_t sb_q[$];
  event chk_ev;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = {31'b0, irq_out[0]};
          2: act = {31'b0, irq_out[1]};
          default: act = {31'b0, wake_req};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(string tag, int kind, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    #1;
  endtask

  task automatic check_outs(string tag);
    expect_item({tag, " irq0"}, 1, {31'b0, exp_irq(0)});
    expect_item({tag, " irq1"}, 2, {31'b0, exp_irq(1)});
    expect_item({tag, " wake"}, 3, {31'b0, exp_wake()});
    flush();
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a[2:0] == 3'd0) en_m[a[4:3]] = d & cov(int'(a[4:3]));
  endtask

  task automatic read_chk(logic [4:0] a, logic [31:0] e, string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    expect_item(tag, 0, e);
    flush();
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < NW; w++) en_m[w] = fwd_m[w] & cov(w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_outs("R1 reset");
    for (int w = 0; w < NW; w++) read_chk(5'(w*8), fwd_m[w] & cov(w), "R1 enable reset value");

    // R5/R6: source 0 of word 0 -> output 0 only, one edge of latency
    src_b[0] = 1'b1;
    #2;
    expect_item("R5 latency before edge", 1, 32'd0);
    flush();
    step();
    check_outs("R5 R6 word0 bit0");
    expect_item("R6 output0 only", 1, 32'd1);
    expect_item("R6 output1 stays low", 2, 32'd0);
    flush();

    // R7: level hold, then release
    step();
    check_outs("R7 held");
    src_b[0] = 1'b0;
    step();
    check_outs("R7 released");
    expect_item("R7 released irq0", 1, 32'd0);
    flush();

    // R3/R10: enable writes masked by coverage
    bus_write(5'h08, 32'hFFFF_FFFF);
    read_chk(5'h08, 32'hFFFF_FFFF, "R3 enable word1 write");
    bus_write(5'h10, 32'hFFFF_FFFF);
    read_chk(5'h10, 32'h0000_0FFF, "R10 enable word2 uncovered bits");
    bus_write(5'h18, 32'hFFFF_FFFF);
    read_chk(5'h18, 32'h0, "R10 enable word3 no coverage");

    // R6: word1 bit0 routed to output 1 only
    src_b[32] = 1'b1;
    step();
    check_outs("R6 word1 bit0");
    expect_item("R6 output1 high", 2, 32'd1);
    expect_item("R6 output0 low", 1, 32'd0);
    flush();

    // R4/R10: status reads, status write ignored
    read_chk(5'h0C, 32'h1, "R4 status word1");
    src_b[127:96] = 32'hFFFF_FFFF;
    read_chk(5'h1C, 32'h0, "R10 status word3 uncovered");
    step();
    check_outs("R10 uncovered source drives nothing");
    src_b[127:96] = 32'h0;
    bus_write(5'h04, 32'hFFFF_FFFF);
    read_chk(5'h00, 32'h11, "R4 status write leaves enable");

    // R2: off-grid offsets read zero
    read_chk(5'h01, 32'h0, "R2 offset 1");
    read_chk(5'h09, 32'h0, "R2 offset 9");
    read_chk(5'h0E, 32'h0, "R2 offset 14");

    // R3 mask, R8 suspend widening, R9 wake
    bus_write(5'h00, 32'h0);
    src_b[32] = 1'b0;
    src_b[8] = 1'b1;
    step();
    check_outs("R3 masked source");
    expect_item("R3 masked irq0", 1, 32'd0);
    flush();
    suspend = 1'b1;
    step();
    check_outs("R8 R9 suspend widen");
    expect_item("R8 wake-enabled irq0", 1, 32'd1);
    expect_item("R9 wake high", 3, 32'd1);
    flush();
    suspend = 1'b0;
    step();
    check_outs("R8 suspend over");
    expect_item("R8 restored irq0", 1, 32'd0);
    flush();

    // R9: wake from word2 bit11 only while suspended
    src_b[8] = 1'b0;
    src_b[64+11] = 1'b1;
    step();
    check_outs("R9 no suspend");
    suspend = 1'b1;
    step();
    check_outs("R9 word2 wake");
    expect_item("R9 wake word2", 3, 32'd1);
    flush();
    src_b[64+11] = 1'b0;
    step();
    check_outs("R9 wake drops");
    suspend = 1'b0;
    step();
    check_outs("R5 idle");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule